// File: doc/BRIEF.md
# LIN Slave Interrupt Vector Encoder

This block collects single-cycle event pulses from the other parts of a LIN slave controller. Those parts are the receiver, the transmitter, the frame parser and the checksum unit. The block keeps each event as a pending flag until software services it. A status vector names the pending event with the highest priority. Software reads that vector, handles the event, and reads again until the vector returns zero. An interrupt request line follows the vector through an enable bit.

The block also holds the bus-idle timer. When no valid break or byte field has been seen for more than 2^IDLE_BITS clocks, the timer raises the no-bus-activity event. With the default of 23 bits and a 6.4 MHz clock, this happens about 1.31 s after the bus goes quiet.

The two receive-complete events behave differently from the rest. Reading the vector does not clear them until software has also read data byte 0.

Top module: `lin_irq_vector`

## Requirements
- R1: The vector equals four times the priority number of the highest pending source, with bits 1:0 and 7:6 always zero. Input bit `ev_pulse[n]` sets the source of priority n. The priorities are:
  - 15: wakeup
  - 13: inconsistent sync field
  - 12: identifier parity error
  - 11: identifier received
  - 10: byte framing error
  - 9: checksum error
  - 7: receiver overrun
  - 6: bit error
  - 5: receive buffer full, no checksum
  - 4: receive complete, checksum OK
  - 3: transmit buffer empty, no checksum
  - 2: transmit complete with checksum
  - 1: no bus activity
- R2: Pulses on `ev_pulse` bits 0, 1, 8 and 14 are ignored, and priorities 8 and 14 are never reported.
- R3: A vector of zero means nothing is pending, and it never produces `irq` = 1, whatever `irq_en` holds.
- R4: `irq` is registered. One clock after a cycle with `irq_en` = 1 and a nonzero vector, it is 1. In every other case it is 0.
- R5: When `vec_rd` is pulsed while a source other than priority 4 or 5 is reported, that source clears. On the next cycle the vector shows the next-highest pending source.
- R6: A `vec_rd` pulse does not clear priority 4 or 5 unless `d0_rd` has been pulsed since that source was last set. A `d0_rd` pulse given before the event does not count.
- R7: After a `d0_rd` pulse, a `vec_rd` pulse while priority 4 or 5 is reported clears that source.
- R8: After the last `bus_valid` pulse (or reset), the priority-1 source becomes pending on the (2^IDLE_BITS + 1)-th clock edge that has no `bus_valid` pulse.
- R9: The idle timer fires only once per idle period. After it fires it stays quiet until a `bus_valid` pulse restarts the count.
- R10: After reset no source is pending, the vector is zero and `irq` is 0.
- R11: If a source's event pulse arrives in the same cycle that the source would be cleared, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 16 | One-cycle event pulses; bit n sets the source of priority n |
| bus_valid | input | 1 | Pulse on every valid break or byte field; restarts the idle timer |
| vec_rd | input | 1 | Status vector read strobe |
| d0_rd | input | 1 | Data byte 0 read strobe |
| irq_en | input | 1 | Interrupt enable |
| vec | output | 8 | Status vector: priority × 4 of the highest pending source |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every strobe and event input lasts one clock and is sampled only while `rst_n` is high. They also assume that the vector is read only through `vec_rd`, which is a single-cycle pulse. The stimulus drives every input on the falling edge and raises each strobe for exactly one cycle. The idle-timer tests shrink `IDLE_BITS` to 4 so that the full timeout window, and a second window after a restart, fit in a short run. Every other sequence keeps `bus_valid` asserted so the idle source stays out of the way.

// File: rtl/lin_irq_vector.sv
module lin_irq_vector #(
  parameter int IDLE_BITS = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ev_pulse,
  input  logic        bus_valid,
  input  logic        vec_rd,
  input  logic        d0_rd,
  input  logic        irq_en,
  output logic [7:0]  vec,
  output logic        irq
);
  localparam logic [15:0]        SRC_MASK = 16'hBEFC;
  localparam logic [IDLE_BITS:0] LIMIT    = {1'b1, {IDLE_BITS{1'b0}}};

  logic [15:0]        flags;
  logic [3:0]         top;
  logic [IDLE_BITS:0] cnt;
  logic               idle_done;
  logic               d0_seen;

  always_comb begin
    top = 4'd0;
    for (int i = 1; i < 16; i++)
      if (flags[i]) top = 4'(i);
  end

  assign vec = {2'b00, top, 2'b00};

  wire        rx_top    = (top == 4'd4) || (top == 4'd5);
  wire        clr_ok    = vec_rd && (top != 4'd0) && (!rx_top || d0_seen);
  wire [15:0] clr       = clr_ok ? (16'd1 << top) : 16'd0;
  wire        idle_fire = !idle_done && (cnt == LIMIT);
  wire [15:0] set       = (ev_pulse & SRC_MASK) | {14'd0, idle_fire, 1'b0};
  wire        rx_set    = |set[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      irq     <= 1'b0;
      d0_seen <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | set;
      irq   <= irq_en && (top != 4'd0);
      if (rx_set)                d0_seen <= 1'b0;
      else if (d0_rd)            d0_seen <= 1'b1;
      else if (clr_ok && rx_top) d0_seen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_valid) begin
      cnt       <= '0;
      idle_done <= 1'b0;
    end else if (idle_fire) begin
      idle_done <= 1'b1;
    end else if (!idle_done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

module lin_irq_vector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  vec,
  input logic        irq,
  input logic        irq_en,
  input logic        vec_rd,
  input logic [15:0] ev_pulse,
  input logic [15:0] flags,
  input logic        d0_seen
);
  assert_zero_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == 8'h00) |=> !irq);

  assert_irq_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && vec != 8'h00) |=> irq);

  assert_irq_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);

  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec[5:2] != 4'd8) && (vec[5:2] != 4'd14) && (vec[1:0] == 2'b00) && (vec[7:6] == 2'b00));

  assert_rx4_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == 8'h10 && !d0_seen) |=> flags[4]);

  assert_rx5_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == 8'h14 && !d0_seen) |=> flags[5]);

  assert_wake_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == 8'h3C && !ev_pulse[15]) |=> !flags[15]);

  assert_pending_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != 8'h00 && !vec_rd) |=> flags[$past(vec[5:2])]);
endmodule

bind lin_irq_vector lin_irq_vector_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vec(vec), .irq(irq), .irq_en(irq_en),
  .vec_rd(vec_rd), .ev_pulse(ev_pulse), .flags(flags), .d0_seen(d0_seen)
);

// File: tb/lin_irq_vector_tb_top.sv
`timescale 1ns/1ps
module lin_irq_vector_tb_top;
  localparam int IB  = 4;
  localparam int LIM = 1 << IB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_pulse = '0;
  logic        bus_valid = 1'b0, vec_rd = 1'b0, d0_rd = 1'b0, irq_en = 1'b0;
  logic [7:0]  vec;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  lin_irq_vector #(.IDLE_BITS(IB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_valid(bus_valid),
    .vec_rd(vec_rd), .d0_rd(d0_rd), .irq_en(irq_en), .vec(vec), .irq(irq));

  always #2.5 clk = ~clk;

  // reference model state
  bit [15:0] m_pend;
  bit        m_irq, m_d0, m_done;
  int        m_cnt;

  function automatic int m_top(bit [15:0] p);
    for (int i = 15; i >= 1; i--) if (p[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_irq = 0; m_d0 = 0; m_done = 0; m_cnt = 0;
    end else begin
      int t;
      bit fire, rxrep, take;
      bit [15:0] nxt;
      t     = m_top(m_pend);
      fire  = !m_done && (m_cnt == LIM);
      rxrep = (t == 4) || (t == 5);
      take  = vec_rd && t != 0 && (!rxrep || m_d0);
      nxt   = m_pend;
      if (take) nxt[t] = 0;
      for (int i = 2; i < 16; i++)
        if (ev_pulse[i] && i != 8 && i != 14) nxt[i] = 1;   // R2 R11
      if (fire) nxt[1] = 1;                                 // R8
      m_irq = irq_en && (t != 0);                           // R3 R4
      if (ev_pulse[4] || ev_pulse[5]) m_d0 = 0;             // R6
      else if (d0_rd) m_d0 = 1;
      else if (take && rxrep) m_d0 = 0;                     // R7
      if (bus_valid) begin m_cnt = 0; m_done = 0; end       // R9
      else if (fire) m_done = 1;
      else if (!m_done) m_cnt++;
      m_pend = nxt;
    end
  end

  // cycle compare against the model (R1 R5 R10)
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (vec !== 8'(m_top(m_pend) * 4) || irq !== m_irq) begin
        n_bad++;
        $display("FAIL R1 R4 model compare: vec=%h irq=%b expected vec=%h irq=%b",
                 vec, irq, 8'(m_top(m_pend) * 4), m_irq);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_ev(logic [15:0] b);
    ev_pulse = b; tick(); ev_pulse = '0;
  endtask

  task automatic rd_vec(); vec_rd = 1; tick(); vec_rd = 0; endtask
  task automatic rd_d0();  d0_rd  = 1; tick(); d0_rd  = 0; endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; bus_valid = 1;
    tick();
    chk("R10 reset vec", vec, 8'h00);
    chk("R10 reset irq", {7'd0, irq}, 8'h00);

    irq_en = 1;
    pulse_ev(16'h1280);                     // priorities 12, 9, 7
    chk("R1 top of three", vec, 8'h30);
    tick();
    chk("R4 irq raised", {7'd0, irq}, 8'h01);
    rd_vec(); chk("R5 next after 12", vec, 8'h24);
    rd_vec(); chk("R5 next after 9", vec, 8'h1C);
    rd_vec(); chk("R5 empty", vec, 8'h00);
    tick();  chk("R3 irq low on zero", {7'd0, irq}, 8'h00);

    pulse_ev(16'h4103);                     // bits 0, 1, 8, 14
    tick();
    chk("R2 reserved ignored", vec, 8'h00);
    chk("R3 no irq", {7'd0, irq}, 8'h00);

    pulse_ev(16'hA000);                     // wakeup and sync error
    chk("R1 wakeup", vec, 8'h3C);
    rd_vec(); chk("R1 sync error", vec, 8'h34);
    rd_vec();

    pulse_ev(16'h0010);
    chk("R1 rx ok", vec, 8'h10);
    rd_vec(); chk("R6 rx4 held", vec, 8'h10);
    rd_d0();
    rd_vec(); chk("R7 rx4 cleared", vec, 8'h00);

    rd_d0();
    pulse_ev(16'h0020);
    rd_vec(); chk("R6 stale d0 read", vec, 8'h14);
    rd_d0();
    rd_vec(); chk("R7 rx5 cleared", vec, 8'h00);

    pulse_ev(16'h000C);
    chk("R1 tx sources", vec, 8'h0C);
    rd_vec(); chk("R5 tx next", vec, 8'h08);
    rd_vec();

    pulse_ev(16'h0200);
    ev_pulse = 16'h0200; vec_rd = 1; tick(); ev_pulse = '0; vec_rd = 0;
    chk("R11 re-set wins", vec, 8'h24);
    rd_vec(); chk("R11 then clears", vec, 8'h00);

    irq_en = 0;
    pulse_ev(16'h0040);
    tick();
    chk("R4 disabled irq", {7'd0, irq}, 8'h00);
    chk("R1 bit error", vec, 8'h18);
    rd_vec();

    // idle timer
    bus_valid = 0;
    repeat (LIM) tick();
    chk("R8 not yet", vec, 8'h00);
    tick();
    chk("R8 idle fired", vec, 8'h04);
    rd_vec();
    repeat (40) tick();
    chk("R9 fires once", vec, 8'h00);
    bus_valid = 1; tick(); bus_valid = 0;
    repeat (LIM + 1) tick();
    chk("R9 restart fires", vec, 8'h04);
    rd_vec();
    bus_valid = 1;
    repeat (3) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule